// File: doc/BRIEF.md
# Flash Command Interface Sequencer

This block sits between a host bus and a NOR-style flash array. It takes bus write cycles (a one-cycle strobe with address and data) and decodes them as commands. It then chooses which source a bus read returns: the array, the status register, the identifier/lock area, or the query area. Single-write commands change the read source. Two-write commands (a setup write, then a confirm write) launch the erase controller, either for one block or for the whole chip.

A command sequence that is not exactly right sends the interface back to array reads. A wrong block-erase confirm also raises two sticky status error bits. From the moment an erase is launched until the controller reports done, reads are forced to return status. During that time only the read-status and suspend commands are acted on. The low-voltage lockout flag and reset both put the interface into array-read mode.

All control and status pins are plain levels or one-cycle pulses. There is no handshake: a write strobe is consumed in the cycle it is seen, and the launch and suspend pulses last exactly one cycle.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset, rd_src_o is 0 (array), sr_err_o is 00, and erase_start_o and suspend_o are low.
- R2: A cycle with lvlo_i high sets array-read mode (rd_src_o 0 unless forced by R5) and cancels any pending setup write. The write in that cycle is discarded.
- R3: The opcodes 0xFF, 0x70, 0x90 and 0x98 each take one write and select rd_src_o = 0 (array), 1 (status), 2 (identifier) and 3 (query) respectively. The selection holds until another command changes it. A setup write (0x20 or 0x80) selects status (1).
- R4: With no setup pending, any opcode outside 0xFF, 0x70, 0x90, 0x98, 0x20, 0x80, 0x50 and 0xB0 selects array mode. A chip-erase setup followed by any byte other than 0x10 selects array mode without launching and without touching sr_err_o.
- R5: While busy_i is high, or an erase has been launched and done_i has not yet been seen, rd_src_o reads 1 (status) whatever mode is selected.
- R6: A write of 0x20 followed by a write of 0xD0 pulses erase_start_o high for one cycle, in the cycle after the confirm write. erase_addr_o carries the confirm write's address and erase_chip_o is 0.
- R7: A write of 0x80 followed by 0x10, at any address, pulses erase_start_o with erase_chip_o = 1 and erase_addr_o = 0.
- R8: A block-erase setup followed by any byte other than 0xD0 sets both sr_err_o bits (bit 1 stands for status bit 5, bit 0 for status bit 4) and selects array mode. It does not launch.
- R9: While an erase is active (R5 condition), 0x70 selects status and 0xB0 pulses suspend_o for one cycle in the following cycle. Every other write leaves the mode, sr_err_o and erase_start_o untouched. Outside an erase, 0xB0 does nothing.
- R10: sr_err_o bits stay set until 0x50 is written outside an active erase, or until reset.
- R11: The active-erase window opens with the erase_start_o pulse and closes on the cycle after done_i is sampled high, even if busy_i has not yet risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvlo_i | input | 1 | Low-voltage lockout flag |
| wr_valid_i | input | 1 | Bus write strobe, one per write cycle |
| wr_addr_i | input | ADDR_W | Bus write address |
| wr_data_i | input | 8 | Bus write data (command byte) |
| busy_i | input | 1 | Erase controller busy |
| done_i | input | 1 | Erase controller finished (one-cycle pulse) |
| rd_src_o | output | 2 | Read source: 0 array, 1 status, 2 identifier, 3 query |
| erase_start_o | output | 1 | One-cycle erase launch pulse |
| erase_addr_o | output | ADDR_W | Address latched with the block-erase confirm |
| erase_chip_o | output | 1 | Launch is a chip erase |
| suspend_o | output | 1 | One-cycle suspend request |
| sr_err_o | output | 2 | Sticky status error bits {bit5, bit4} |

## Verification
The hardest state to reach is the gap between launch and the rise of busy_i. In that window only the internal active flag forces status reads and blocks commands. Directed steps hold busy_i low after a confirm, write array-read and clear-status into the gap, and then check that neither took effect. A second hard case is a clear-status written during an erase while error bits are already set. The stimulus first aborts a block erase, then launches one, so that the clear arrives while the erase is active. Random traffic, with a bench-side controller that replies with variable busy lengths, then mixes these cases with lockout pulses.

// File: rtl/fci_pkg.sv
package fci_pkg;
  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_IDENT  = 2'd2,
    SRC_QUERY  = 2'd3
  } src_e;

  typedef enum logic [3:0] {
    OP_RD_ARRAY, OP_RD_STATUS, OP_RD_IDENT, OP_RD_QUERY,
    OP_BLK_SETUP, OP_CHIP_SETUP, OP_BLK_CONF, OP_CHIP_CONF,
    OP_SUSPEND, OP_CLR_STAT, OP_OTHER
  } op_e;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_BLK  = 2'd1,
    PEND_CHIP = 2'd2
  } pend_e;

  localparam int CMD_W = 8;
  localparam logic [CMD_W-1:0] C_RD_ARRAY  = 8'hFF;
  localparam logic [CMD_W-1:0] C_RD_STATUS = 8'h70;
  localparam logic [CMD_W-1:0] C_RD_IDENT  = 8'h90;
  localparam logic [CMD_W-1:0] C_RD_QUERY  = 8'h98;
  localparam logic [CMD_W-1:0] C_BLK_SETUP = 8'h20;
  localparam logic [CMD_W-1:0] C_CHIP_SET  = 8'h80;
  localparam logic [CMD_W-1:0] C_BLK_CONF  = 8'hD0;
  localparam logic [CMD_W-1:0] C_CHIP_CONF = 8'h10;
  localparam logic [CMD_W-1:0] C_SUSPEND   = 8'hB0;
  localparam logic [CMD_W-1:0] C_CLR_STAT  = 8'h50;
endpackage

// File: rtl/fci_decode.sv
module fci_decode
  import fci_pkg::*;
(
  input  logic [CMD_W-1:0] byte_i,
  output op_e              op_o
);
  always_comb begin
    unique case (byte_i)
      C_RD_ARRAY:  op_o = OP_RD_ARRAY;
      C_RD_STATUS: op_o = OP_RD_STATUS;
      C_RD_IDENT:  op_o = OP_RD_IDENT;
      C_RD_QUERY:  op_o = OP_RD_QUERY;
      C_BLK_SETUP: op_o = OP_BLK_SETUP;
      C_CHIP_SET:  op_o = OP_CHIP_SETUP;
      C_BLK_CONF:  op_o = OP_BLK_CONF;
      C_CHIP_CONF: op_o = OP_CHIP_CONF;
      C_SUSPEND:   op_o = OP_SUSPEND;
      C_CLR_STAT:  op_o = OP_CLR_STAT;
      default:     op_o = OP_OTHER;
    endcase
  end
endmodule

// File: rtl/fci_errflags.sv
module fci_errflags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_i,
  input  logic       clr_i,
  output logic [1:0] err_o
);
  logic [1:0] err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     err_q <= 2'b00;
    else if (set_i) err_q <= 2'b11;
    else if (clr_i) err_q <= 2'b00;
  end

  assign err_o = err_q;

  // R8: an abort leaves both bits set
  assert_abort_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (err_o == 2'b11));

  // R10: a bit only drops after a clear request
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(err_o[0]) || $fell(err_o[1])) |-> $past(clr_i));
endmodule

// File: rtl/fci_launch.sv
module fci_launch #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_blk_i,
  input  logic              go_chip_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              done_i,
  output logic              start_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              chip_o,
  output logic              active_o
);
  logic              start_q, chip_q, act_q;
  logic [ADDR_W-1:0] addr_q;
  logic              go;

  assign go = go_blk_i | go_chip_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      chip_q  <= 1'b0;
      act_q   <= 1'b0;
      addr_q  <= '0;
    end else begin
      start_q <= go;
      if (go) begin
        addr_q <= go_blk_i ? addr_i : '0;
        chip_q <= go_chip_i;
      end
      if (go)          act_q <= 1'b1;
      else if (done_i) act_q <= 1'b0;
    end
  end

  assign start_o  = start_q;
  assign addr_o   = addr_q;
  assign chip_o   = chip_q;
  assign active_o = act_q;

  // R6: launch is a single-cycle pulse
  assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  // R11: window is open whenever the pulse is seen and closes after done
  assert_window_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> active_o);
  assert_window_close_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !go) |=> !active_o);
endmodule

// File: rtl/fci_rdsel.sv
module fci_rdsel
  import fci_pkg::*;
(
  input  src_e       mode_i,
  input  logic       force_i,
  output logic [1:0] src_o
);
  always_comb begin
    src_o = force_i ? SRC_STATUS : mode_i;
  end
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import fci_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvlo_i,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              busy_i,
  input  logic              done_i,
  output logic [1:0]        rd_src_o,
  output logic              erase_start_o,
  output logic [ADDR_W-1:0] erase_addr_o,
  output logic              erase_chip_o,
  output logic              suspend_o,
  output logic [1:0]        sr_err_o
);
  src_e  mode_q, mode_n;
  pend_e pend_q, pend_n;
  op_e   op;
  logic  active, blocked;
  logic  go_blk, go_chip, err_set, err_clr, susp_n, susp_q;

  fci_decode u_dec (.byte_i(wr_data_i), .op_o(op));

  assign blocked = active | busy_i;

  always_comb begin
    mode_n  = mode_q;
    pend_n  = pend_q;
    go_blk  = 1'b0;
    go_chip = 1'b0;
    err_set = 1'b0;
    err_clr = 1'b0;
    susp_n  = 1'b0;
    if (lvlo_i) begin
      mode_n = SRC_ARRAY;
      pend_n = PEND_NONE;
    end else if (wr_valid_i) begin
      if (blocked) begin
        if (op == OP_RD_STATUS) mode_n = SRC_STATUS;
        if (op == OP_SUSPEND)   susp_n = 1'b1;
      end else begin
        unique case (pend_q)
          PEND_BLK: begin
            pend_n = PEND_NONE;
            if (op == OP_BLK_CONF) begin
              go_blk = 1'b1;
              mode_n = SRC_STATUS;
            end else begin
              err_set = 1'b1;
              mode_n  = SRC_ARRAY;
            end
          end
          PEND_CHIP: begin
            pend_n = PEND_NONE;
            if (op == OP_CHIP_CONF) begin
              go_chip = 1'b1;
              mode_n  = SRC_STATUS;
            end else begin
              mode_n = SRC_ARRAY;
            end
          end
          default: begin
            unique case (op)
              OP_RD_ARRAY:   mode_n = SRC_ARRAY;
              OP_RD_STATUS:  mode_n = SRC_STATUS;
              OP_RD_IDENT:   mode_n = SRC_IDENT;
              OP_RD_QUERY:   mode_n = SRC_QUERY;
              OP_BLK_SETUP:  begin pend_n = PEND_BLK;  mode_n = SRC_STATUS; end
              OP_CHIP_SETUP: begin pend_n = PEND_CHIP; mode_n = SRC_STATUS; end
              OP_CLR_STAT:   err_clr = 1'b1;
              OP_SUSPEND:    ;
              default:       mode_n = SRC_ARRAY;
            endcase
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SRC_ARRAY;
      pend_q <= PEND_NONE;
      susp_q <= 1'b0;
    end else begin
      mode_q <= mode_n;
      pend_q <= pend_n;
      susp_q <= susp_n;
    end
  end

  fci_errflags u_err (
    .clk(clk), .rst_n(rst_n), .set_i(err_set), .clr_i(err_clr), .err_o(sr_err_o)
  );

  fci_launch #(.ADDR_W(ADDR_W)) u_launch (
    .clk(clk), .rst_n(rst_n), .go_blk_i(go_blk), .go_chip_i(go_chip),
    .addr_i(wr_addr_i), .done_i(done_i), .start_o(erase_start_o),
    .addr_o(erase_addr_o), .chip_o(erase_chip_o), .active_o(active)
  );

  fci_rdsel u_rdsel (.mode_i(mode_q), .force_i(blocked), .src_o(rd_src_o));

  assign suspend_o = susp_q;

  // R2: lockout lands in array mode with nothing pending
  assert_lockout_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lvlo_i |=> (mode_q == SRC_ARRAY && pend_q == PEND_NONE));

  // R5: controller busy forces status reads
  assert_busy_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> (rd_src_o == SRC_STATUS));

  // R8: wrong block confirm aborts to array with error bits
  assert_bad_confirm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvlo_i && wr_valid_i && !blocked && pend_q == PEND_BLK && wr_data_i != C_BLK_CONF)
    |=> (sr_err_o == 2'b11 && mode_q == SRC_ARRAY && !erase_start_o));

  // R9: other writes during an erase change nothing
  assert_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvlo_i && wr_valid_i && blocked && wr_data_i != C_RD_STATUS)
    |=> ($stable(mode_q) && $stable(sr_err_o) && !erase_start_o));
endmodule

// File: tb/flash_cmd_if_tb.sv
`timescale 1ns/1ps
module flash_cmd_if_tb;
  localparam int AW = 18;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, lvlo, wr_valid, busy, done;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [1:0]    rd_src, sr_err;
  logic          erase_start, erase_chip, suspend;
  logic [AW-1:0] erase_addr;

  flash_cmd_if #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .lvlo_i(lvlo), .wr_valid_i(wr_valid),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .busy_i(busy), .done_i(done),
    .rd_src_o(rd_src), .erase_start_o(erase_start), .erase_addr_o(erase_addr),
    .erase_chip_o(erase_chip), .suspend_o(suspend), .sr_err_o(sr_err)
  );

  int total = 0, bad = 0;
  bit ended = 0;

  // reference model state
  int m_mode, m_pend, m_err;
  bit m_run, e_start, e_chip, e_susp;
  int e_addr;
  int ctl = 0;
  bit auto_ctl = 0;
  bit man_busy = 0, man_done = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model(bit w, int d, int a, bit lv, bit b, bit dn);
    bit blk = m_run || b;
    e_start = 0; e_susp = 0;
    if (lv) begin
      m_mode = 0; m_pend = 0;
    end else if (w) begin
      if (blk) begin
        if (d == 'h70) m_mode = 1;
        if (d == 'hB0) e_susp = 1;
      end else if (m_pend == 1) begin
        m_pend = 0;
        if (d == 'hD0) begin e_start = 1; e_chip = 0; e_addr = a; m_mode = 1; end
        else begin m_err = 3; m_mode = 0; end
      end else if (m_pend == 2) begin
        m_pend = 0;
        if (d == 'h10) begin e_start = 1; e_chip = 1; e_addr = 0; m_mode = 1; end
        else m_mode = 0;
      end else begin
        case (d)
          'hFF: m_mode = 0;
          'h70: m_mode = 1;
          'h90: m_mode = 2;
          'h98: m_mode = 3;
          'h20: begin m_pend = 1; m_mode = 1; end
          'h80: begin m_pend = 2; m_mode = 1; end
          'h50: m_err = 0;
          'hB0: ;
          default: m_mode = 0;
        endcase
      end
    end
    if (dn) m_run = 0;
    if (e_start) m_run = 1;
  endfunction

  task automatic step(bit w, int d, int a, bit lv);
    wr_valid = w; wr_data = d[7:0]; wr_addr = a[AW-1:0]; lvlo = lv;
    if (auto_ctl) begin busy = (ctl > 0); done = (ctl == 1); end
    else begin busy = man_busy; done = man_done; end
    @(posedge clk);
    model(w, d, a, lv, busy, done);
    if (ctl > 0) ctl--;
    if (e_start && auto_ctl) ctl = 3 + int'($urandom % 6);
    #2;
    chk("R3 R5 rd_src", rd_src, (busy || m_run) ? 1 : m_mode);
    chk("R6 R7 erase_start", erase_start, e_start);
    if (e_start) begin
      chk("R6 R7 erase_chip", erase_chip, e_chip);
      chk("R6 R7 erase_addr", erase_addr, e_addr);
    end
    chk("R8 R10 sr_err", sr_err, m_err);
    chk("R9 suspend", suspend, e_susp);
  endtask

  initial begin
    #1500000;
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; lvlo = 0; wr_valid = 0; wr_data = 0; wr_addr = 0; busy = 0; done = 0;
    m_mode = 0; m_pend = 0; m_err = 0; m_run = 0; e_addr = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 rd_src", rd_src, 0);
    chk("R1 sr_err", sr_err, 0);
    chk("R1 erase_start", erase_start, 0);
    chk("R1 suspend", suspend, 0);

    // R3 read modes
    step(1, 'h90, 5, 0); chk("R3 ident", rd_src, 2);
    step(0, 0, 0, 0);    chk("R3 ident holds", rd_src, 2);
    step(1, 'h98, 7, 0); chk("R3 query", rd_src, 3);
    step(1, 'h70, 0, 0); chk("R3 status", rd_src, 1);
    // R4 unknown opcode
    step(1, 'h33, 0, 0); chk("R4 unknown", rd_src, 0);
    // R9 suspend outside erase does nothing
    step(1, 'h90, 0, 0);
    step(1, 'hB0, 0, 0); chk("R9 idle suspend", rd_src, 2);
    // R2 lockout cancels pending setup
    step(1, 'h20, 0, 0);
    step(0, 0, 0, 1);    chk("R2 lockout", rd_src, 0);
    step(1, 'hD0, 9, 0); chk("R2 no launch", erase_start, 0);
    // R8 bad block confirm
    step(1, 'h20, 0, 0);
    step(1, 'h70, 0, 0); chk("R8 err bits", sr_err, 3); chk("R8 array", rd_src, 0);
    // R10 error persists across commands
    step(1, 'h90, 0, 0); chk("R10 sticky", sr_err, 3);
    // R4 chip bad confirm: array, no flags change
    step(1, 'h80, 0, 0);
    step(1, 'h11, 0, 0); chk("R4 chip bad", rd_src, 0);
    // R6 block erase, R11 gap before busy
    step(1, 'h20, 0, 0);
    step(1, 'hD0, 'h2A5C3, 0); chk("R6 start", erase_start, 1); chk("R6 addr", erase_addr, 'h2A5C3);
    step(1, 'hFF, 0, 0); chk("R11 gap forced status", rd_src, 1);
    step(1, 'h50, 0, 0); chk("R9 clear ignored", sr_err, 3);
    step(1, 'h20, 0, 0);
    step(1, 'hD0, 1, 0); chk("R9 no relaunch", erase_start, 0);
    man_busy = 1;
    step(1, 'hB0, 0, 0); chk("R9 suspend", suspend, 1);
    man_done = 1;
    step(0, 0, 0, 0);
    man_busy = 0; man_done = 0;
    step(0, 0, 0, 0); chk("R11 closed status mode", rd_src, 1);
    step(1, 'h50, 0, 0); chk("R10 cleared", sr_err, 0);
    // R7 chip erase at arbitrary address
    step(1, 'h80, 'h1234, 0);
    step(1, 'h10, 'h3FFFF, 0); chk("R7 chip", erase_chip, 1); chk("R7 addr", erase_addr, 0);
    man_done = 1; step(0, 0, 0, 0); man_done = 0;
    step(1, 'hFF, 0, 0); chk("R11 after done", rd_src, 0);

    // random traffic
    auto_ctl = 1;
    for (int i = 0; i < 4000; i++) begin
      int sel = int'($urandom % 16);
      int d;
      case (sel)
        0: d = 'hFF; 1: d = 'h70; 2: d = 'h90; 3: d = 'h98;
        4, 5: d = 'h20; 6: d = 'h80; 7, 8: d = 'hD0; 9: d = 'h10;
        10: d = 'hB0; 11: d = 'h50;
        default: d = int'($urandom % 256);
      endcase
      step(($urandom % 4) != 0, d, int'($urandom % (1 << AW)), ($urandom % 50) == 0);
    end

    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule